// File: doc/BRIEF.md
# Symmetric Bit-Parallel Distributed-Arithmetic FIR Filter

This block is an eight-tap FIR filter for 8-bit signed samples. Its coefficients are fixed when the block is elaborated, and it replaces multipliers with small lookup tables. The coefficients are symmetric, so the delay line first adds each pair of mirrored taps into a 9-bit sum. Bit j of the four pair sums then forms a 4-bit address into lookup table j. Table j holds every subset sum of the four coefficients, already scaled by 2^j. The table for the top bit plane is negated, which gives the two's-complement weight of the sign bit.

All nine bit planes are looked up in the same clock, so the filter accepts one sample and produces one result per clock. The lookup contents are computed from the coefficient parameter during elaboration. Tables for low bit planes store fewer bits because they are floored to the working precision. A registered adder tree sums the plane results. Its last adder is split into 4-bit slices with a register after each slice. The output is the full-precision result divided by 256 and rounded down. An upstream stage presents a sample with `x_vld_i`, and a downstream stage takes the result when `y_vld_o` is high.

Top module: `da_fir_sym`

## Requirements
- R1: A sample on `x_i` enters the delay line on a rising edge where `x_vld_i` is 1. A cycle with `x_vld_i` at 0 leaves the delay line unchanged, so later results are as if that cycle never happened.
- R2: Taps k and 7-k both use coefficient c_k, for k = 0..3. Parameter `COEFS` holds c_k as a signed 8-bit value in bits [8k+7:8k].
- R3: Pair sums are 9-bit two's complement. Plane 8, the sign plane, carries weight -2^8, so negative samples down to -128 filter correctly.
- R4: Let L_j be the sum of the c_i whose pair sum i has bit j set, and let s_j be -1 for j = 8 and +1 otherwise. Then `y_o` (11-bit signed) is floor(A/4), where A = sum over j = 0..8 of floor(s_j * L_j * 2^j / 64). The internal sum never leaves the range of `y_o`.
- R5: For every input history, 0 <= F - 256*`y_o` <= 1024, where F = sum of c_k*(x[n-k] + x[n-7+k]) at full precision.
- R6: The result for a sample appears on `y_o`, with `y_vld_o` high, right after the 14th rising edge, counting the edge that samples the input as the first. `y_vld_o` is high only in those cycles.
- R7: Samples presented on consecutive clocks give results on consecutive clocks.
- R8: When `rst_ni` is low, `y_o` and `y_vld_o` clear at once and the delay line clears. The first results after reset treat all earlier samples as zero.
- R9: The final adder works in 4-bit slices with a register after each slice. Its result equals the full-width sum of its operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 8 | Signed input sample |
| x_vld_i | input | 1 | Sample on `x_i` is valid |
| y_o | output | 11 | Signed filtered result, full result divided by 256 and rounded down |
| y_vld_o | output | 1 | Result on `y_o` is valid |

## Verification
The hardest case to reach is a sign plane that takes part while the low planes carry large flooring losses. This combination decides both the negative weight and the 1024-LSB error bound. The stimulus reaches it in three ways: it sends an impulse for every one of the 256 input values, it holds long runs at -128 and at 127, and it alternates between the two extremes. It then runs a long pseudo-random stream and a stream with idle gaps, and it resets in the middle of a stream. Every result is compared with the bit-exact flooring formula and with the full-precision error bound.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // bits kept in the lookup table of plane j; planes below g are floored
  function automatic int plane_w(int j, int g, int lw, int msb);
    if (j < g) return lw - (g - j);
    return lw + (j - g) + ((j == msb) ? 1 : 0);
  endfunction

  // operand count after lvl halving stages of the adder tree
  function automatic int tree_cnt(int n, int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = (c + 1) / 2;
    return c;
  endfunction

  // halving stages until two operands remain for the final adder
  function automatic int tree_depth(int n);
    int d;
    int c;
    d = 0;
    c = n;
    while (c > 2) begin
      c = (c + 1) / 2;
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/da_fir_preadd.sv
module da_fir_preadd #(
  parameter int NTAP = 8,
  parameter int DW   = 8,
  localparam int HALF = NTAP / 2,
  localparam int PSW  = DW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [DW-1:0]  x_i,
  input  logic                  vld_i,
  output logic signed [PSW-1:0] pair_o [HALF],
  output logic                  vld_o
);

  logic signed [DW-1:0] dly [NTAP];
  logic                 v1, v2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAP; k++) dly[k] <= '0;
    end else if (vld_i) begin
      dly[0] <= x_i;
      for (int k = 1; k < NTAP; k++) dly[k] <= dly[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HALF; i++) pair_o[i] <= '0;
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      for (int i = 0; i < HALF; i++)
        pair_o[i] <= {dly[i][DW-1], dly[i]} + {dly[NTAP-1-i][DW-1], dly[NTAP-1-i]};
      v1 <= vld_i;
      v2 <= v1;
    end
  end

  assign vld_o = v2;

  assert_shift_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> dly[0] == $past(x_i));

  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(dly[0]) && $stable(dly[NTAP-1]));

  assert_valid_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(vld_i, 2));

endmodule

// File: rtl/da_fir_planes.sv
module da_fir_planes
  import da_fir_pkg::*;
#(
  parameter int HALF  = 4,
  parameter int CW    = 8,
  parameter int PSW   = 9,
  parameter int G     = 6,
  parameter int ACC_W = 16,
  parameter logic [HALF*CW-1:0] COEFS = '0,
  localparam int LW   = CW + $clog2(HALF),
  localparam int NPL  = PSW,
  localparam int NENT = 1 << HALF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [PSW-1:0]   pair_i [HALF],
  input  logic                    vld_i,
  output logic signed [ACC_W-1:0] term_o [NPL],
  output logic                    vld_o
);

  // floor(sign * subset_sum * 2^j / 2^G); sign plane negated
  function automatic int lut_entry(int j, int addr);
    int s;
    s = 0;
    for (int i = 0; i < HALF; i++)
      if (addr[i]) s += int'($signed(COEFS[i*CW +: CW]));
    if (j == NPL - 1) s = -s;
    s = s <<< j;
    return s >>> G;
  endfunction

  for (genvar j = 0; j < NPL; j++) begin : g_pl
    localparam int PW = plane_w(j, G, LW, NPL - 1);
    logic [HALF-1:0]        addr;
    logic signed [PW-1:0]   tbl [NENT];
    logic signed [PW-1:0]   q;

    for (genvar i = 0; i < HALF; i++) begin : g_ad
      assign addr[i] = pair_i[i][j];
    end
    for (genvar e = 0; e < NENT; e++) begin : g_ent
      assign tbl[e] = PW'(lut_entry(j, e));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= tbl[addr];
    end

    assign term_o[j] = ACC_W'(q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

endmodule

// File: rtl/da_fir_slice_add.sv
module da_fir_slice_add #(
  parameter int W  = 16,
  parameter int SL = 4,
  localparam int NS = (W + SL - 1) / SL,
  localparam int PW = NS * SL
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  logic [PW-1:0] a_x, b_x;
  logic [PW-1:0] a_r   [NS];
  logic [PW-1:0] b_r   [NS];
  logic [PW-1:0] acc_r [NS];
  logic          c_r   [NS];
  logic [SL:0]   part  [NS];

  assign a_x = PW'(a_i);
  assign b_x = PW'(b_i);

  for (genvar s = 0; s < NS; s++) begin : g_sl
    if (s == 0) begin : g_first
      assign part[s] = {1'b0, a_x[0 +: SL]} + {1'b0, b_x[0 +: SL]};
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_r[s] <= '0; b_r[s] <= '0; acc_r[s] <= '0; c_r[s] <= 1'b0;
        end else begin
          a_r[s]   <= a_x;
          b_r[s]   <= b_x;
          acc_r[s] <= PW'(part[s][SL-1:0]);
          c_r[s]   <= part[s][SL];
        end
      end
    end else begin : g_next
      assign part[s] = {1'b0, a_r[s-1][s*SL +: SL]} + {1'b0, b_r[s-1][s*SL +: SL]}
                     + {{SL{1'b0}}, c_r[s-1]};
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_r[s] <= '0; b_r[s] <= '0; acc_r[s] <= '0; c_r[s] <= 1'b0;
        end else begin
          a_r[s]   <= a_r[s-1];
          b_r[s]   <= b_r[s-1];
          acc_r[s] <= acc_r[s-1];
          acc_r[s][s*SL +: SL] <= part[s][SL-1:0];
          c_r[s]   <= part[s][SL];
        end
      end
    end
  end

  assign sum_o = acc_r[NS-1][W-1:0];

  // cycles since reset, saturating, so the check never reaches before reset
  logic [$clog2(NS+1):0] warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       warm <= '0;
    else if (warm < NS) warm <= warm + 1'b1;
  end

  // NS = W/SL is a handful of stages
  assert_slice_sum_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == NS) |-> sum_o == $past(a_i + b_i, NS));

endmodule

// File: rtl/da_fir_accum.sv
module da_fir_accum
  import da_fir_pkg::*;
#(
  parameter int NPL   = 9,
  parameter int ACC_W = 16,
  parameter int OUT_W = 11,
  parameter int GUARD = 2,
  parameter int SLICE = 4,
  parameter int ALIGN = 3,
  localparam int NLV  = tree_depth(NPL),
  localparam int NS   = (ACC_W + SLICE - 1) / SLICE,
  localparam int VD   = NS + 1 + ALIGN
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ACC_W-1:0] term_i [NPL],
  input  logic                    vld_i,
  output logic signed [OUT_W-1:0] y_o,
  output logic                    vld_o
);

  for (genvar l = 0; l <= NLV; l++) begin : g_lv
    localparam int CNT = tree_cnt(NPL, l);
    logic signed [ACC_W-1:0] s [CNT];
    logic                    v;

    if (l == 0) begin : g_in
      for (genvar i = 0; i < CNT; i++) begin : g_el
        assign s[i] = term_i[i];
      end
      assign v = vld_i;
    end else begin : g_add
      localparam int PC = tree_cnt(NPL, l - 1);
      for (genvar i = 0; i < CNT; i++) begin : g_el
        logic signed [ACC_W-1:0] r;
        if (2*i + 1 < PC) begin : g_two
          always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) r <= '0;
            else         r <= g_lv[l-1].s[2*i] + g_lv[l-1].s[2*i+1];
          end
        end else begin : g_one
          always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) r <= '0;
            else         r <= g_lv[l-1].s[2*i];
          end
        end
        assign s[i] = r;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v <= 1'b0;
        else         v <= g_lv[l-1].v;
      end
    end
  end

  logic [ACC_W-1:0]        add_sum;
  logic signed [ACC_W-1:0] add_s;

  da_fir_slice_add #(.W(ACC_W), .SL(SLICE)) u_fin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (g_lv[NLV].s[0]),
    .b_i   (g_lv[NLV].s[1]),
    .sum_o (add_sum)
  );

  assign add_s = $signed(add_sum);

  logic signed [OUT_W-1:0] yd [ALIGN+1];
  logic                    vd [VD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= ALIGN; k++) yd[k] <= '0;
      for (int k = 0; k < VD; k++)     vd[k] <= 1'b0;
    end else begin
      yd[0] <= OUT_W'(add_s >>> GUARD);
      for (int k = 1; k <= ALIGN; k++) yd[k] <= yd[k-1];
      vd[0] <= g_lv[NLV].v;
      for (int k = 1; k < VD; k++) vd[k] <= vd[k-1];
    end
  end

  assign y_o   = yd[ALIGN];
  assign vld_o = vd[VD-1];

  // bits above the kept field must all be sign copies
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&add_s[ACC_W-1:GUARD+OUT_W-1]) || !(|add_s[ACC_W-1:GUARD+OUT_W-1]));

endmodule

// File: rtl/da_fir_sym.sv
module da_fir_sym #(
  parameter int NTAP  = 8,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter logic [NTAP/2*CW-1:0] COEFS = 32'h7F46_17F7,
  parameter int TRUNC = 8,
  parameter int GUARD = 2,
  parameter int SLICE = 4,
  parameter int ALIGN = 3,
  localparam int HALF  = NTAP / 2,
  localparam int PSW   = DW + 1,
  localparam int FW    = PSW + CW + $clog2(HALF),
  localparam int G     = TRUNC - GUARD,
  localparam int ACC_W = FW - G + 3,
  localparam int OUT_W = FW - TRUNC
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [DW-1:0]    x_i,
  input  logic                    x_vld_i,
  output logic signed [OUT_W-1:0] y_o,
  output logic                    y_vld_o
);

  logic signed [PSW-1:0]   pair [HALF];
  logic                    pair_vld;
  logic signed [ACC_W-1:0] term [PSW];
  logic                    term_vld;

  da_fir_preadd #(.NTAP(NTAP), .DW(DW)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (x_i),
    .vld_i (x_vld_i),
    .pair_o(pair),
    .vld_o (pair_vld)
  );

  da_fir_planes #(
    .HALF(HALF), .CW(CW), .PSW(PSW), .G(G), .ACC_W(ACC_W), .COEFS(COEFS)
  ) u_pl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pair_i(pair),
    .vld_i (pair_vld),
    .term_o(term),
    .vld_o (term_vld)
  );

  da_fir_accum #(
    .NPL(PSW), .ACC_W(ACC_W), .OUT_W(OUT_W), .GUARD(GUARD),
    .SLICE(SLICE), .ALIGN(ALIGN)
  ) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .term_i(term),
    .vld_i (term_vld),
    .y_o   (y_o),
    .vld_o (y_vld_o)
  );

endmodule

// File: tb/tb_da_fir_sym.sv
module tb_da_fir_sym;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [7:0] x = '0;
  logic              xv = 1'b0;
  logic signed [10:0] y;
  logic              yv;

  int c [4] = '{-9, 23, 70, 127};
  int hist [8];
  bit ev [32];
  int ey [32];
  int ef [32];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string req = "R8";
  logic [31:0] rs = 32'h1234_5678;

  da_fir_sym #(.COEFS(32'h7F46_17F7)) dut (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .x_vld_i(xv), .y_o(y), .y_vld_o(yv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pair_of(int i);
    return hist[i] + hist[7-i];
  endfunction

  // R4 flooring rule, evaluated on the bench history
  function automatic int model_y();
    int acc;
    acc = 0;
    for (int j = 0; j < 9; j++) begin
      int l;
      int t;
      l = 0;
      for (int i = 0; i < 4; i++) begin
        logic [8:0] p;
        p = 9'(pair_of(i));
        if (p[j]) l += c[i];
      end
      t = (j == 8) ? -l : l;
      t = t <<< j;
      acc += (t >>> 6);
    end
    return acc >>> 2;
  endfunction

  function automatic int model_full();
    int f;
    f = 0;
    for (int i = 0; i < 4; i++) f += c[i] * pair_of(i);
    return f;
  endfunction

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic fail(string r, int act, int exp);
    n_fail++;
    $display("FAIL %s cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
  endtask

  task automatic check_out();
    int idx;
    int yi;
    idx = (cyc + 32 - LAT) % 32;
    yi = y;
    n_chk++;
    if (yv !== ev[idx]) fail("R6 valid", int'(yv), int'(ev[idx]));
    if (ev[idx] && yv === 1'b1) begin
      n_chk++;
      if (yi != ey[idx]) fail({req, " R4 value"}, yi, ey[idx]);
      n_chk++;
      if (ef[idx] - 256 * yi < 0 || ef[idx] - 256 * yi > 1024)
        fail("R5 error bound", ef[idx] - 256 * yi, ef[idx]);
    end
  endtask

  task automatic step(input logic v, input int val);
    @(negedge clk);
    check_out();
    x  = 8'(val);
    xv = v;
    if (v) begin
      for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'($signed(8'(val)));
    end
    ev[cyc % 32] = v;
    ey[cyc % 32] = model_y();
    ef[cyc % 32] = model_full();
    cyc++;
  endtask

  task automatic clear_model();
    for (int k = 0; k < 8; k++) hist[k] = 0;
    for (int k = 0; k < 32; k++) begin ev[k] = 1'b0; ey[k] = 0; ef[k] = 0; end
    cyc = 0;
  endtask

  // R8: outputs clear as soon as reset is applied
  task automatic do_reset();
    @(negedge clk);
    xv = 1'b0;
    rst_n = 1'b0;
    #1;
    n_chk++;
    if (yv !== 1'b0) fail("R8 valid in reset", int'(yv), 0);
    n_chk++;
    if (y !== '0) fail("R8 data in reset", int'(y), 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (4) @(negedge clk);
    n_chk++;
    if (yv !== 1'b0 || y !== '0) fail("R8 reset state", int'(y), 0);
    do_reset();

    // R2: impulse for every input value shows c0..c3 then mirrored
    req = "R2";
    for (int v = -128; v < 128; v++) begin
      step(1'b1, v);
      for (int k = 0; k < 7; k++) step(1'b1, 0);
    end

    // R3: sign plane at the extremes
    req = "R3";
    for (int k = 0; k < 64; k++) step(1'b1, -128);
    for (int k = 0; k < 64; k++) step(1'b1, (k % 2) ? 127 : -128);
    for (int k = 0; k < 64; k++) step(1'b1, 127);

    // R7 R9: back-to-back random stream, carries across all slices
    req = "R7 R9";
    for (int k = 0; k < 40000; k++) step(1'b1, int'(rnd() & 32'hFF));

    // R1: idle cycles with garbage on x_i must not disturb the delay line
    req = "R1";
    for (int k = 0; k < 6000; k++) begin
      logic [31:0] r;
      r = rnd();
      step(r[1:0] != 2'b00, int'(r[15:8]));
    end

    // R8: reset during a stream; history restarts from zero
    req = "R8";
    for (int k = 0; k < 20; k++) step(1'b1, int'(rnd() & 32'hFF));
    do_reset();
    for (int k = 0; k < 200; k++) step(1'b1, int'(rnd() & 32'hFF));
    for (int k = 0; k < 20; k++) step(1'b0, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule